// File: doc/BRIEF.md
# Parallel Port Negotiation Event Detector

This block watches two host control lines of a bidirectional parallel port (IEEE 1284) and sorts their transitions into three events, all in one system clock domain. Line A is active high and counts on its rising edge. Line B is active low and counts on its falling edge. The same two wires carry ordinary transfer strobes, where the lines move in different samples. During the start of a mode negotiation they move together. The block tells these cases apart by checking whether both lines changed in the same clock sample.

Both lines are asynchronous. Each one passes through a synchronizer chain of configurable depth. A register holds the synchronized value from the previous sample. The block compares the current and previous pairs and finds that both lines moved when at least one line differs from its old value while the XOR of the pair keeps its old value. A coincident A rise with B fall sets a sticky negotiation flag, which stays set until a synchronous clear. A B fall while A stays high gives a one-cycle nibble-read strobe. A B fall while A is low gives a one-cycle compatibility-write strobe. Downstream logic uses the flag to leave the current transfer mode and enter negotiation, and it uses the strobes to drive transfers.

Top module: `pp_negotiation_detector`

## Requirements
- R1: While `rst_n` is low and after it is released, all three outputs are low. The synchronizers and the previous-value register start at the idle levels, A low and B high, so idle lines after reset produce no event.
- R2: A change on the lines first shows on an output at the (SYNC_STAGES+1)-th rising clock edge after the inputs are first sampled. SYNC_STAGES edges are spent in the synchronizer and one in the output register.
- R3: When synchronized A goes 0 to 1 and synchronized B goes 1 to 0 in the same sample, `neg_flag_o` becomes 1.
- R4: An A rise and a B fall that land in different samples never set `neg_flag_o`.
- R5: Once set, `neg_flag_o` stays 1 on every following cycle until a clear is applied.
- R6: When synchronized B goes 1 to 0 while synchronized A is 1 in both the previous and the current sample, `nibble_rd_o` is 1 for exactly one cycle.
- R7: When synchronized B goes 1 to 0 while synchronized A is 0 in the current sample, `compat_wr_o` is 1 for exactly one cycle.
- R8: At most one of the three events fires in any sample. A coincident A rise with B fall raises neither strobe.
- R9: When `neg_clr_i` is 1 at a rising edge, `neg_flag_o` is 0 after that edge. If a coincident event is detected at the same edge, the set wins and the flag is 1.
- R10: The other transitions produce no output: A rise alone, A fall alone, B rise alone, and A fall together with B rise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_a_i | input | 1 | Host control line A, active high, asynchronous |
| line_b_i | input | 1 | Host control line B, active low, asynchronous |
| neg_clr_i | input | 1 | Synchronous clear of the negotiation flag, active high |
| neg_flag_o | output | 1 | Sticky negotiation-detected flag |
| nibble_rd_o | output | 1 | One-cycle nibble-read strobe |
| compat_wr_o | output | 1 | One-cycle compatibility-write strobe |

## Verification
The bench builds the block with SYNC_STAGES set to 3, not the default of 2. This way the latency checks confirm that the delay follows the parameter and is not hard-wired at two flops. With the deeper chain, directed sequences can place an A rise and a B fall one sample apart and in the same sample, and the bench can check the exact edge where each output first moves. A long pseudo-random stretch of line and clear activity then reaches the rarer combinations: a clear on the same edge as a set, a simultaneous A fall with B rise, and back-to-back strobes.

// File: rtl/ppneg_pkg.sv
`timescale 1ns/1ps
package ppneg_pkg;
    // Synchronized state of the two host control lines
    typedef struct packed {
        logic a;   // active high line
        logic b;   // active low line
    } line_pair_t;

    // One-sample classification result
    typedef struct packed {
        logic coinc;   // A rise together with B fall
        logic nibble;  // B fall, A high and steady
        logic compat;  // B fall, A low
    } evt_t;

    localparam logic IDLE_A = 1'b0;
    localparam logic IDLE_B = 1'b1;
endpackage

// File: rtl/ppneg_sync.sv
`timescale 1ns/1ps
module ppneg_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = din;
        end else begin : g_chain
            always_comb chain_d = {chain_q[STAGES-2:0], din};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/ppneg_classify.sv
`timescale 1ns/1ps
module ppneg_classify
    import ppneg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  line_pair_t cur_i,
    output evt_t       evt_o
);
    typedef struct packed {
        line_pair_t prev;
    } cls_state_t;

    cls_state_t st_d, st_q;
    logic moved, parity_same, both_moved, a_rise, b_fall;

    always_comb begin
        st_d        = st_q;
        st_d.prev   = cur_i;
        moved       = (cur_i.a ^ st_q.prev.a) | (cur_i.b ^ st_q.prev.b);
        parity_same = (cur_i.a ^ cur_i.b) == (st_q.prev.a ^ st_q.prev.b);
        both_moved  = moved & parity_same;
        a_rise      = cur_i.a & ~st_q.prev.a;
        b_fall      = ~cur_i.b & st_q.prev.b;
        evt_o.coinc  = both_moved & a_rise & ~cur_i.b;
        evt_o.nibble = b_fall & cur_i.a & st_q.prev.a;
        evt_o.compat = b_fall & ~cur_i.a;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.prev.a <= IDLE_A;
            st_q.prev.b <= IDLE_B;
        end else begin
            st_q <= st_d;
        end
    end

    // R2: previous-value register holds the last synchronized sample
    a_r2_prev_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.prev == $past(cur_i));
    // R8: one event class per sample at most
    a_r8_one_event: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(evt_o));
endmodule

// File: rtl/ppneg_flags.sv
`timescale 1ns/1ps
module ppneg_flags
    import ppneg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  evt_t evt_i,
    input  logic clr_i,
    output logic neg_o,
    output logic nib_o,
    output logic cw_o
);
    typedef struct packed {
        logic neg;
        logic nib;
        logic cw;
    } flag_t;

    flag_t fl_d, fl_q;

    always_comb begin
        fl_d     = fl_q;
        fl_d.nib = evt_i.nibble;
        fl_d.cw  = evt_i.compat;
        if (evt_i.coinc)  fl_d.neg = 1'b1;
        else if (clr_i)   fl_d.neg = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fl_q <= '0;
        else        fl_q <= fl_d;
    end

    assign neg_o = fl_q.neg;
    assign nib_o = fl_q.nib;
    assign cw_o  = fl_q.cw;

    // R5: flag holds while no clear is requested
    a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_q.neg && !clr_i) |=> fl_q.neg);
    // R9: clear without a simultaneous event drops the flag
    a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !evt_i.coinc) |=> !fl_q.neg);
    // R9: a detected coincidence always leaves the flag set
    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i.coinc |=> fl_q.neg);
    // R6: nibble strobe never spans two cycles
    a_r6_single_nib: assert property (@(posedge clk) disable iff (!rst_n)
        fl_q.nib |=> !fl_q.nib);
    // R7: compatibility strobe never spans two cycles
    a_r7_single_cw: assert property (@(posedge clk) disable iff (!rst_n)
        fl_q.cw |=> !fl_q.cw);
endmodule

// File: rtl/pp_negotiation_detector.sv
`timescale 1ns/1ps
module pp_negotiation_detector
    import ppneg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_a_i,
    input  logic line_b_i,
    input  logic neg_clr_i,
    output logic neg_flag_o,
    output logic nibble_rd_o,
    output logic compat_wr_o
);
    line_pair_t sync_pair;
    evt_t       evt;

    ppneg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(IDLE_A)) u_sync_a (
        .clk(clk), .rst_n(rst_n), .din(line_a_i), .dout(sync_pair.a));

    ppneg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(IDLE_B)) u_sync_b (
        .clk(clk), .rst_n(rst_n), .din(line_b_i), .dout(sync_pair.b));

    ppneg_classify u_classify (
        .clk(clk), .rst_n(rst_n), .cur_i(sync_pair), .evt_o(evt));

    ppneg_flags u_flags (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .clr_i(neg_clr_i),
        .neg_o(neg_flag_o), .nib_o(nibble_rd_o), .cw_o(compat_wr_o));

    // R8: the two strobes never appear together
    a_r8_strobes_apart: assert property (@(posedge clk) disable iff (!rst_n)
        !(nibble_rd_o && compat_wr_o));
endmodule

// File: tb/test_pp_negotiation_detector.sv
`timescale 1ns/1ps
module test_pp_negotiation_detector;
    localparam int STG = 3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic la = 1'b0, lb = 1'b1, clr = 1'b0;
    logic neg, nib, cw;
    int n_run = 0, n_fail = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    pp_negotiation_detector #(.SYNC_STAGES(STG)) i_pp_negotiation_detector (
        .clk(clk), .rst_n(rst_n), .line_a_i(la), .line_b_i(lb),
        .neg_clr_i(clr), .neg_flag_o(neg), .nibble_rd_o(nib), .compat_wr_o(cw));

    // Behavioural reference: delay lines, then edge rules on the delayed pair
    bit ma [STG];
    bit mb [STG];
    bit mpa, mpb, mneg, mnib, mcw;

    always @(posedge clk) begin : ref_model
        bit as, bs, a_up, b_down;
        if (!rst_n) begin
            for (int i = 0; i < STG; i++) begin ma[i] = 0; mb[i] = 1; end
            mpa = 0; mpb = 1; mneg = 0; mnib = 0; mcw = 0;
        end else begin
            as = ma[STG-1]; bs = mb[STG-1];
            a_up   = (as == 1) && (mpa == 0);
            b_down = (bs == 0) && (mpb == 1);
            mnib = b_down && as && mpa;
            mcw  = b_down && !as;
            if (a_up && b_down) mneg = 1;
            else if (clr)       mneg = 0;
            mpa = as; mpb = bs;
            for (int i = STG-1; i > 0; i--) begin ma[i] = ma[i-1]; mb[i] = mb[i-1]; end
            ma[0] = la; mb[0] = lb;
        end
    end

    task automatic chk(input logic act, input logic exp, input string tag);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the reference
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(neg, mneg, "R5 flag vs model");
            chk(nib, mnib, "R6 nibble vs model");
            chk(cw,  mcw,  "R7 compat vs model");
        end
    end

    task automatic drive(input logic a, input logic b);
        @(negedge clk); la = a; lb = b;
    endtask

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin : watchdog
        #1000000;
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : stim
        int seed;
        waitn(3);
        chk(neg, 0, "R1 reset flag");
        chk(nib, 0, "R1 reset nibble");
        chk(cw,  0, "R1 reset compat");
        @(negedge clk); rst_n = 1'b1;
        waitn(STG + 3);
        chk(neg | nib | cw, 0, "R1 idle after reset");

        // Coincident A rise with B fall, latency check
        drive(1, 0);
        waitn(STG);
        chk(neg, 0, "R2 not before latency");
        waitn(1);
        chk(neg, 1, "R3 coincident sets flag");
        chk(nib | cw, 0, "R8 no strobe on coincidence");
        waitn(5);
        chk(neg, 1, "R5 flag holds");

        // Clear
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        chk(neg, 0, "R9 clear drops flag");

        // B rise alone with A high
        drive(1, 1);
        waitn(STG + 2);
        chk(neg | nib | cw, 0, "R10 B rise alone quiet");

        // Nibble read: B falls, A steady high
        drive(1, 0);
        waitn(STG + 1);
        chk(nib, 1, "R6 nibble strobe");
        chk(cw, 0, "R8 compat idle during nibble");
        waitn(1);
        chk(nib, 0, "R6 nibble single cycle");

        // A fall alone, then B rise
        drive(0, 0);
        waitn(STG + 2);
        chk(neg | nib | cw, 0, "R10 A fall alone quiet");
        drive(0, 1);
        waitn(STG + 2);

        // A rise then B fall one sample later
        drive(1, 1);
        drive(1, 0);
        waitn(STG + 3);
        chk(neg, 0, "R4 separate samples no flag");

        // A fall with B rise together, then compat write
        drive(0, 1);
        waitn(STG + 2);
        chk(neg | nib | cw, 0, "R10 A fall with B rise quiet");
        drive(0, 0);
        waitn(STG + 1);
        chk(cw, 1, "R7 compat strobe");
        chk(nib, 0, "R8 nibble idle during compat");
        waitn(1);
        chk(cw, 0, "R7 compat single cycle");

        // Set wins over simultaneous clear
        drive(0, 1);
        waitn(STG + 2);
        @(negedge clk); la = 1; lb = 0; clr = 1'b1;
        waitn(STG + 1);
        chk(neg, 1, "R9 set beats clear");
        clr = 1'b0;
        waitn(2);
        chk(neg, 1, "R5 flag holds after set");

        // Pseudo-random stretch checked by the model
        seed = 32'h1234_5678;
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk);
            seed = seed * 1103515245 + 12345;
            la  = seed[16];
            lb  = seed[19];
            clr = (seed[23:21] == 3'd0);
        end
        waitn(STG + 2);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule